// File: doc/BRIEF.md
# Zero Common-Mode Sequence Selector for Multilevel PWM

This block runs once per carrier period in a space-vector modulator for an odd-level (n-level) three-phase inverter that must keep the common-mode voltage at zero. It takes three normalized phase references, each between 0 and n-1 in unsigned Q4.12 form. It splits every reference into an integer base level and a fractional active duty. From the sum of the three base levels it picks one of two switching patterns. It then ranks the three duties, gives each phase one of three active-sequence roles (Y1, Y2, Y3), and decides which of two four-state sequence families gives the lower ripple. It uses a multiply-and-compare test on the sorted duties for that choice.

A control processor or an upstream sampler pulses `start_i` with a new sample. Three cycles later `done_o` pulses and the registered results are ready for the duty-time and gate-timing stages downstream. If the base-level sum fits neither pattern, the block reports an error and keeps its last good results.

Top module: `zcmv_seq_select`

## Requirements
- R1: For a reference below n-1, the base level is the integer part (bits 15:12) and the duty is the 12-bit fraction, presented as a 13-bit value where 4096 stands for 1.0.
- R2: A reference equal to or above n-1 gives base level n-2 and duty 4096. No base output ever exceeds n-2 and no duty output exceeds 4096.
- R3: Let FL be the sum of the three base levels. FL = 3(n-1)/2-1 selects pattern I (`pat_o`=0). FL = 3(n-1)/2-2 selects pattern II (`pat_o`=1).
- R4: Duties are ranked largest first. When two duties are equal, the phase earlier in the order A, B, C ranks higher.
- R5: Under pattern I, the top-ranked phase gets role Y3 (code 3), the middle phase gets Y1 (code 1) and the lowest phase gets Y2 (code 2).
- R6: Under pattern II, the lowest-ranked phase gets Y3 (code 3), the middle phase gets Y1 (code 1) and the top phase gets Y2 (code 2).
- R7: Under pattern I, `grp_o`=1 (second family) when 2·dmin·(1-dmin) ≥ dmax·dmid. Otherwise `grp_o`=0. The comparison is exact, and equality selects the second family.
- R8: Under pattern II, `grp_o`=1 when 2·dmax·(1-dmax) ≥ (1-dmid)·(1-dmin). Otherwise `grp_o`=0.
- R9: A `start_i` pulse sampled at one clock edge makes `done_o` high for exactly one cycle, three cycles after the cycle that carried the pulse. `done_o` never pulses without such a start.
- R10: If FL matches neither pattern value, `err_o` is set with `done_o` and every result output keeps its previous value. The next valid sample clears `err_o`.
- R11: After reset, every output is zero.
- R12: Result outputs change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample strobe for the three references |
| ref_a_i | input | 16 | Phase A reference, unsigned Q4.12 |
| ref_b_i | input | 16 | Phase B reference, unsigned Q4.12 |
| ref_c_i | input | 16 | Phase C reference, unsigned Q4.12 |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Base-level sum matched no pattern on the last sample |
| base_a_o | output | 2 | Phase A base level |
| base_b_o | output | 2 | Phase B base level |
| base_c_o | output | 2 | Phase C base level |
| duty_a_o | output | 13 | Phase A duty, 4096 = 1.0 |
| duty_b_o | output | 13 | Phase B duty |
| duty_c_o | output | 13 | Phase C duty |
| pat_o | output | 1 | 0 = pattern I, 1 = pattern II |
| grp_o | output | 1 | 0 = first sequence family, 1 = second family |
| role_a_o | output | 2 | Phase A role: 1 = Y1, 2 = Y2, 3 = Y3 |
| role_b_o | output | 2 | Phase B role |
| role_c_o | output | 2 | Phase C role |

## Verification
Every internal state is flushed within three cycles of a start, so a fault appears in the one `done_o` cycle of the sample that exposes it. A bad rank comparator or tie rule shows as two phases with the same role, or as the roles of the top and lowest phases swapped. A wrong operand in the ripple test flips `grp_o` only for duty sets near the decision boundary. For that reason the exact-equality case is driven on purpose. A stuck pipeline valid shows as a missing or extra `done_o`, and a broken hold path shows as results that change on an error sample.

// File: rtl/zcmv_pkg.sv
package zcmv_pkg;

  localparam int NPH = 3;

  typedef enum logic [1:0] {
    ROLE_NONE = 2'd0,
    ROLE_Y1   = 2'd1,
    ROLE_Y2   = 2'd2,
    ROLE_Y3   = 2'd3
  } role_e;

endpackage

// File: rtl/zcmv_ref_split.sv
module zcmv_ref_split #(
  parameter int NLEV = 5,
  parameter int IW   = 4,
  parameter int FW   = 12,
  parameter int LW   = 2
) (
  input  logic [IW+FW-1:0] ref_i,
  output logic [LW-1:0]    base_o,
  output logic [FW:0]      duty_o
);

  localparam int RW = IW + FW;
  localparam logic [IW-1:0] TOP_INT = IW'(NLEV - 1);
  localparam logic [LW-1:0] TOP_BASE = LW'(NLEV - 2);
  localparam logic [FW:0]   ONE = {1'b1, {FW{1'b0}}};

  logic [IW-1:0] int_part;

  assign int_part = ref_i[RW-1:FW];

  // Saturate at the top level so the duty can reach a full 1.0
  always_comb begin
    if (int_part >= TOP_INT) begin
      base_o = TOP_BASE;
      duty_o = ONE;
    end else begin
      base_o = LW'(int_part);
      duty_o = {1'b0, ref_i[FW-1:0]};
    end
  end

endmodule

// File: rtl/zcmv_duty_rank.sv
module zcmv_duty_rank
  import zcmv_pkg::*;
#(
  parameter int DW = 13
) (
  input  logic [NPH-1:0][DW-1:0] duty_i,
  input  logic                   pat2_i,
  output logic [NPH-1:0][1:0]    role_o,
  output logic [DW-1:0]          dmax_o,
  output logic [DW-1:0]          dmid_o,
  output logic [DW-1:0]          dmin_o
);

  logic [NPH-1:0][1:0] pos;

  // Pairwise ranking: on a tie the lower phase index wins
  always_comb begin
    pos = '0;
    for (int i = 0; i < NPH; i++) begin
      for (int j = i + 1; j < NPH; j++) begin
        if (duty_i[i] >= duty_i[j]) pos[j] = pos[j] + 2'd1;
        else                        pos[i] = pos[i] + 2'd1;
      end
    end
  end

  always_comb begin
    dmax_o = '0;
    dmid_o = '0;
    dmin_o = '0;
    for (int i = 0; i < NPH; i++) begin
      case (pos[i])
        2'd0:    dmax_o = duty_i[i];
        2'd1:    dmid_o = duty_i[i];
        default: dmin_o = duty_i[i];
      endcase
    end
  end

  // Role by rank; the pattern decides which end of the order takes Y3
  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      case (pos[i])
        2'd0:    role_o[i] = pat2_i ? ROLE_Y2 : ROLE_Y3;
        2'd1:    role_o[i] = ROLE_Y1;
        default: role_o[i] = pat2_i ? ROLE_Y3 : ROLE_Y2;
      endcase
    end
  end

endmodule

// File: rtl/zcmv_group_judge.sv
module zcmv_group_judge #(
  parameter int FW = 12
) (
  input  logic        pat2_i,
  input  logic [FW:0] dmax_i,
  input  logic [FW:0] dmid_i,
  input  logic [FW:0] dmin_i,
  output logic        grp2_o
);

  localparam int DW = FW + 1;
  localparam int PW = 2 * DW + 1;
  localparam logic [DW-1:0] ONE = {1'b1, {FW{1'b0}}};

  logic [DW-1:0] l_x;
  logic [DW-1:0] r_a;
  logic [DW-1:0] r_b;
  logic [PW-1:0] lhs;
  logic [PW-1:0] rhs;

  // Operands are steered by pattern so that only two multipliers exist
  always_comb begin
    if (pat2_i) begin
      l_x = dmax_i;
      r_a = ONE - dmid_i;
      r_b = ONE - dmin_i;
    end else begin
      l_x = dmin_i;
      r_a = dmax_i;
      r_b = dmid_i;
    end
  end

  always_comb begin
    lhs    = (PW'(l_x) * PW'(ONE - l_x)) << 1;
    rhs    = PW'(r_a) * PW'(r_b);
    grp2_o = (lhs >= rhs);
  end

endmodule

// File: rtl/zcmv_seq_select.sv
module zcmv_seq_select
  import zcmv_pkg::*;
#(
  parameter int NLEV = 5,
  parameter int IW   = 4,
  parameter int FW   = 12,
  parameter int LW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IW+FW-1:0] ref_a_i,
  input  logic [IW+FW-1:0] ref_b_i,
  input  logic [IW+FW-1:0] ref_c_i,
  output logic             done_o,
  output logic             err_o,
  output logic [LW-1:0]    base_a_o,
  output logic [LW-1:0]    base_b_o,
  output logic [LW-1:0]    base_c_o,
  output logic [FW:0]      duty_a_o,
  output logic [FW:0]      duty_b_o,
  output logic [FW:0]      duty_c_o,
  output logic             pat_o,
  output logic             grp_o,
  output logic [1:0]       role_a_o,
  output logic [1:0]       role_b_o,
  output logic [1:0]       role_c_o
);

  localparam int RW  = IW + FW;
  localparam int DW  = FW + 1;
  localparam int FLW = LW + 2;
  localparam logic [FLW-1:0] FL_PAT1 = FLW'(3 * (NLEV - 1) / 2 - 1);
  localparam logic [FLW-1:0] FL_PAT2 = FLW'(3 * (NLEV - 1) / 2 - 2);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // ---------------- stage 1: split ----------------
  logic [NPH-1:0][RW-1:0] ref_w;
  logic [NPH-1:0][LW-1:0] base_w;
  logic [NPH-1:0][DW-1:0] duty_w;

  assign ref_w[0] = ref_a_i;
  assign ref_w[1] = ref_b_i;
  assign ref_w[2] = ref_c_i;

  for (genvar g = 0; g < NPH; g++) begin : g_split
    zcmv_ref_split #(
      .NLEV(NLEV), .IW(IW), .FW(FW), .LW(LW)
    ) u_split (
      .ref_i (ref_w[g]),
      .base_o(base_w[g]),
      .duty_o(duty_w[g])
    );
  end

  logic                   s1_vld_q;
  logic [NPH-1:0][LW-1:0] s1_base_q;
  logic [NPH-1:0][DW-1:0] s1_duty_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s1_vld_q <= 1'b0;
    else             s1_vld_q <= start_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_base_q <= '0;
      s1_duty_q <= '0;
    end else if (start_i) begin
      s1_base_q <= base_w;
      s1_duty_q <= duty_w;
    end
  end

  // ---------------- stage 2: pattern, rank, roles ----------------
  logic [FLW-1:0]         fl_w;
  logic                   pat2_w;
  logic                   fl_bad_w;
  logic [NPH-1:0][1:0]    role_w;
  logic [DW-1:0]          dmax_w;
  logic [DW-1:0]          dmid_w;
  logic [DW-1:0]          dmin_w;

  always_comb begin
    fl_w = '0;
    for (int i = 0; i < NPH; i++) fl_w = fl_w + FLW'(s1_base_q[i]);
    pat2_w   = (fl_w == FL_PAT2);
    fl_bad_w = (fl_w != FL_PAT1) && (fl_w != FL_PAT2);
  end

  zcmv_duty_rank #(.DW(DW)) u_rank (
    .duty_i(s1_duty_q),
    .pat2_i(pat2_w),
    .role_o(role_w),
    .dmax_o(dmax_w),
    .dmid_o(dmid_w),
    .dmin_o(dmin_w)
  );

  logic                   s2_vld_q;
  logic                   s2_bad_q;
  logic                   s2_pat2_q;
  logic [NPH-1:0][1:0]    s2_role_q;
  logic [NPH-1:0][LW-1:0] s2_base_q;
  logic [NPH-1:0][DW-1:0] s2_duty_q;
  logic [DW-1:0]          s2_dmax_q;
  logic [DW-1:0]          s2_dmid_q;
  logic [DW-1:0]          s2_dmin_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s2_vld_q <= 1'b0;
    else             s2_vld_q <= s1_vld_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_bad_q  <= 1'b0;
      s2_pat2_q <= 1'b0;
      s2_role_q <= '0;
      s2_base_q <= '0;
      s2_duty_q <= '0;
      s2_dmax_q <= '0;
      s2_dmid_q <= '0;
      s2_dmin_q <= '0;
    end else if (s1_vld_q) begin
      s2_bad_q  <= fl_bad_w;
      s2_pat2_q <= pat2_w;
      s2_role_q <= role_w;
      s2_base_q <= s1_base_q;
      s2_duty_q <= s1_duty_q;
      s2_dmax_q <= dmax_w;
      s2_dmid_q <= dmid_w;
      s2_dmin_q <= dmin_w;
    end
  end

  // ---------------- stage 3: family decision, result registers ----------------
  logic grp2_w;

  zcmv_group_judge #(.FW(FW)) u_judge (
    .pat2_i(s2_pat2_q),
    .dmax_i(s2_dmax_q),
    .dmid_i(s2_dmid_q),
    .dmin_i(s2_dmin_q),
    .grp2_o(grp2_w)
  );

  logic                   res_en;
  logic                   done_q;
  logic                   err_q;
  logic                   pat_q;
  logic                   grp_q;
  logic [NPH-1:0][1:0]    role_q;
  logic [NPH-1:0][LW-1:0] base_q;
  logic [NPH-1:0][DW-1:0] duty_q;

  assign res_en = s2_vld_q && !s2_bad_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= s2_vld_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   err_q <= 1'b0;
    else if (s2_vld_q) err_q <= s2_bad_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pat_q  <= 1'b0;
      grp_q  <= 1'b0;
      role_q <= '0;
      base_q <= '0;
      duty_q <= '0;
    end else if (res_en) begin
      pat_q  <= s2_pat2_q;
      grp_q  <= grp2_w;
      role_q <= s2_role_q;
      base_q <= s2_base_q;
      duty_q <= s2_duty_q;
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign pat_o    = pat_q;
  assign grp_o    = grp_q;
  assign base_a_o = base_q[0];
  assign base_b_o = base_q[1];
  assign base_c_o = base_q[2];
  assign duty_a_o = duty_q[0];
  assign duty_b_o = duty_q[1];
  assign duty_c_o = duty_q[2];
  assign role_a_o = role_q[0];
  assign role_b_o = role_q[1];
  assign role_c_o = role_q[2];

endmodule

// File: rtl/zcmv_seq_select_chk.sv
module zcmv_seq_select_chk #(
  parameter int NLEV = 5,
  parameter int FW   = 12,
  parameter int LW   = 2
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          start_i,
  input logic          done_o,
  input logic          err_o,
  input logic [LW-1:0] base_a_o,
  input logic [LW-1:0] base_b_o,
  input logic [LW-1:0] base_c_o,
  input logic [FW:0]   duty_a_o,
  input logic [FW:0]   duty_b_o,
  input logic [FW:0]   duty_c_o,
  input logic          pat_o,
  input logic          grp_o,
  input logic [1:0]    role_a_o,
  input logic [1:0]    role_b_o,
  input logic [1:0]    role_c_o
);

  localparam logic [FW:0]   ONE = {1'b1, {FW{1'b0}}};
  localparam logic [LW-1:0] TOP_BASE = LW'(NLEV - 2);

  logic [3*LW+3*(FW+1)+8-1:0] res_w;
  logic [3:0]                 role_set;

  assign res_w = {base_a_o, base_b_o, base_c_o, duty_a_o, duty_b_o, duty_c_o,
                  pat_o, grp_o, role_a_o, role_b_o, role_c_o};
  assign role_set = (4'b1 << role_a_o) | (4'b1 << role_b_o) | (4'b1 << role_c_o);

  a_r9_done_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |-> ##3 done_o);

  a_r9_done_needs_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> $past(start_i, 3));

  a_r12_quiet_results: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_o |-> $stable(res_w));

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && err_o) |-> $stable(res_w));

  a_r2_base_cap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (base_a_o <= TOP_BASE) && (base_b_o <= TOP_BASE) && (base_c_o <= TOP_BASE));

  a_r2_duty_cap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (duty_a_o <= ONE) && (duty_b_o <= ONE) && (duty_c_o <= ONE));

  a_r5_roles_distinct: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && !err_o) |-> (role_set == 4'b1110));

endmodule

bind zcmv_seq_select zcmv_seq_select_chk #(
  .NLEV(NLEV), .FW(FW), .LW(LW)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .start_i   (start_i),
  .done_o    (done_o),
  .err_o     (err_o),
  .base_a_o  (base_a_o),
  .base_b_o  (base_b_o),
  .base_c_o  (base_c_o),
  .duty_a_o  (duty_a_o),
  .duty_b_o  (duty_b_o),
  .duty_c_o  (duty_c_o),
  .pat_o     (pat_o),
  .grp_o     (grp_o),
  .role_a_o  (role_a_o),
  .role_b_o  (role_b_o),
  .role_c_o  (role_c_o)
);

// File: tb/zcmv_seq_select_tb.sv
module zcmv_seq_select_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] ref_a_i, ref_b_i, ref_c_i;
  logic        done_o, err_o, pat_o, grp_o;
  logic [1:0]  base_a_o, base_b_o, base_c_o;
  logic [12:0] duty_a_o, duty_b_o, duty_c_o;
  logic [1:0]  role_a_o, role_b_o, role_c_o;

  int n_chk = 0;
  int n_bad = 0;

  zcmv_seq_select u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ref_a_i(ref_a_i), .ref_b_i(ref_b_i), .ref_c_i(ref_c_i),
    .done_o(done_o), .err_o(err_o),
    .base_a_o(base_a_o), .base_b_o(base_b_o), .base_c_o(base_c_o),
    .duty_a_o(duty_a_o), .duty_b_o(duty_b_o), .duty_c_o(duty_c_o),
    .pat_o(pat_o), .grp_o(grp_o),
    .role_a_o(role_a_o), .role_b_o(role_b_o), .role_c_o(role_c_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive a sample, sample results in the done cycle, then check done drops
  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    @(negedge clk);
    ref_a_i = a; ref_b_i = b; ref_c_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R9 done low before latency", int'(done_o), 0);
    @(negedge clk);
    chk("R9 done after three cycles", int'(done_o), 1);
  endtask

  task automatic after_done;
    @(negedge clk);
    chk("R9 done one cycle wide", int'(done_o), 0);
  endtask

  task automatic expect_all(input string tag,
      input int ba, input int bb, input int bc,
      input int da, input int db, input int dc,
      input int pat, input int grp,
      input int ra, input int rb, input int rc, input int err);
    chk({tag, " R10 err"}, int'(err_o), err);
    chk({tag, " R1 base A"}, int'(base_a_o), ba);
    chk({tag, " R1 base B"}, int'(base_b_o), bb);
    chk({tag, " R1 base C"}, int'(base_c_o), bc);
    chk({tag, " R1 duty A"}, int'(duty_a_o), da);
    chk({tag, " R1 duty B"}, int'(duty_b_o), db);
    chk({tag, " R1 duty C"}, int'(duty_c_o), dc);
    chk({tag, " R3 pattern"}, int'(pat_o), pat);
    chk({tag, " R7/R8 family"}, int'(grp_o), grp);
    chk({tag, " R4 role A"}, int'(role_a_o), ra);
    chk({tag, " R4 role B"}, int'(role_b_o), rb);
    chk({tag, " R4 role C"}, int'(role_c_o), rc);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b0;
    ref_a_i = '0; ref_b_i = '0; ref_c_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset done", int'(done_o), 0);
    expect_all("R11 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Pattern I, B/C tie broken toward B, second family
  task automatic t_pat1_tie;
    run(16'h2800, 16'h1400, 16'h2400);
    expect_all("R5 p1 tie", 2, 1, 2, 2048, 1024, 1024, 0, 1, 3, 1, 2, 0);
    after_done();
  endtask

  // Pattern I, zero minimum duty forces the first family
  task automatic t_pat1_family1;
    run(16'h1800, 16'h2800, 16'h2000);
    expect_all("R7 p1 fam1", 1, 2, 2, 2048, 2048, 0, 0, 0, 3, 1, 2, 0);
    after_done();
  endtask

  // Pattern II, A/C tie at the top, B lowest takes Y3
  task automatic t_pat2_basic;
    run(16'h1C00, 16'h1800, 16'h2C00);
    expect_all("R6 p2", 1, 1, 2, 3072, 2048, 3072, 1, 1, 2, 3, 1, 0);
    after_done();
  endtask

  // Pattern II with A at the top level: cap, full duty, first family
  task automatic t_pat2_top;
    run(16'h4000, 16'h0800, 16'h1800);
    expect_all("R2 R8 p2 top", 3, 0, 1, 4096, 2048, 2048, 1, 0, 2, 1, 3, 0);
    after_done();
  endtask

  // Invalid base sum: error set, results held from the previous sample
  task automatic t_bad_sum;
    run(16'h0000, 16'h0000, 16'h0000);
    expect_all("R10 hold", 3, 0, 1, 4096, 2048, 2048, 1, 0, 2, 1, 3, 1);
    after_done();
  endtask

  // Exact equality of both sides selects the second family; error clears
  task automatic t_pat1_equal;
    run(16'h1C00, 16'h2800, 16'h2400);
    expect_all("R7 equal", 1, 2, 2, 3072, 2048, 1024, 0, 1, 3, 1, 2, 0);
    after_done();
  endtask

  // Pattern I with C largest
  task automatic t_pat1_c_top;
    run(16'h1400, 16'h2200, 16'h2A00);
    expect_all("R5 c top", 1, 2, 2, 1024, 512, 2560, 0, 1, 1, 2, 3, 0);
    after_done();
  endtask

  // Reference far above n-1 saturates like n-1
  task automatic t_saturate;
    run(16'h7F00, 16'h0800, 16'h1800);
    expect_all("R2 saturate", 3, 0, 1, 4096, 2048, 2048, 1, 0, 2, 1, 3, 0);
    after_done();
  endtask

  // Idle cycles keep results steady
  task automatic t_idle;
    repeat (5) @(negedge clk);
    chk("R12 idle done", int'(done_o), 0);
    expect_all("R12 idle", 3, 0, 1, 4096, 2048, 2048, 1, 0, 2, 1, 3, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pat1_tie();
    t_pat1_family1();
    t_pat2_basic();
    t_pat2_top();
    t_bad_sum();
    t_pat1_equal();
    t_pat1_c_top();
    t_saturate();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule